// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Controller

This block holds two time-of-day alarms and compares them with the current time once per second. Each alarm has four fields: seconds, minutes, hours and day. Bit 7 of every field is a "don't care" bit, so one alarm can fire every second, every minute, every hour, every day or once a week. The timekeeping counters sit outside the block. Their packed-BCD values arrive on `now_*` pins, and a one-cycle `upd_i` strobe marks each clock update.

When an alarm matches, its sticky request flag is set. The flag drives the interrupt pin for that alarm only while its enable bit is set. A control byte holds a write-protect bit, the two interrupt enables and an enable for the 1 Hz square-wave output. While write protect is set, every register write is dropped except the write that clears protect.

Registers are reached through a request channel and a response channel, both valid/ready. Address bit 7 selects a write. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Only reads produce a response. `req_ready` is low while a response is pending and `rsp_ready` is low, so a response is never overwritten or lost. Writes take no response beat, but they are still held off by the same back-pressure.

Top module: `tod_alarm_ctrl`

## Requirements
- R1: For seconds, minutes and hours, the alarm field bits 6:0 are compared with the time. For the day, bits 2:0 are compared. Any field whose bit 7 is 1 counts as matching, so with all four bit-7 masks set the alarm fires on every update.
- R2: An alarm flag is set only in the cycle after an `upd_i` strobe on which that alarm matched. Without a strobe, no flag rises.
- R3: A flag stays set until a request is taken for any of that alarm's four register addresses, read or write. A match on the same cycle as that access leaves the flag set.
- R4: `alm_irq[k]` is high exactly when flag k and interrupt enable k are both 1. The status byte shows the flags whatever the enables are.
- R5: Control read is at address 0x0F and control write at 0x8F. In the control byte, bit 6 is write protect, bit 2 is the square-wave enable, bit 1 is enable 1 and bit 0 is enable 0; the other bits read 0. The status byte is read at 0x10, with bit 0 for flag 0, bit 1 for flag 1 and other bits 0. Status is read-only.
- R6: While write protect is 1, alarm writes are dropped and control bits 2:0 keep their value. Only bit 6 of a control write is taken, so the other bits change only once protect is 0.
- R7: After reset the control byte reads 0x40, all flags and alarm fields read 0, `alm_irq` is 0, `sq_oe` is 0 and `sq_out` is 0.
- R8: `sq_out` toggles on each `half_i` strobe, and `sq_oe` equals control bit 2.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A response held under back-pressure keeps `rsp_valid` high and `rsp_data` stable.
- R10: Alarm 0 fields (seconds, minutes, hours, day) sit at read addresses 0x07 to 0x0A and alarm 1 at 0x0B to 0x0E. Each write address is the read address plus 0x80. Unmapped reads return 0 and unmapped writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | One-cycle clock-update strobe, once per second |
| half_i | input | 1 | One-cycle strobe every half second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_day | input | 8 | Current day of week |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_addr | input | 8 | Bit 7 set for write, bits 6:0 register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response data |
| alm_irq | output | 2 | Interrupt per alarm, active high |
| sq_out | output | 1 | 1 Hz square wave |
| sq_oe | output | 1 | Output enable for the square wave |

## Verification
Every result is due exactly one clock after the edge that takes its cause:
- A write is visible to a read issued on the next cycle.
- A read's `rsp_data` is valid the cycle after the request is taken.
- A flag, and its `alm_irq` pin, changes one cycle after the edge that samples `upd_i`.
- `sq_out` changes one cycle after the edge that samples `half_i`.

The bench drives all inputs on the falling edge and samples on the next falling edge. Every check therefore sees the state one rising edge after its stimulus. Under back-pressure, the response is re-sampled over several held cycles.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int DW     = 8;
  localparam int NFIELD = 4;
  localparam int NALM   = 2;
  localparam int IW     = $clog2(NFIELD);
  localparam int AW     = 7;
  localparam int TIME_W = 7;
  localparam int DAY_W  = 3;

  localparam logic [AW-1:0] A_ALM0 = 7'h07;
  localparam logic [AW-1:0] A_CTRL = 7'h0F;
  localparam logic [AW-1:0] A_STAT = 7'h10;

  localparam int CB_WP = 6;
  localparam int CB_SQ = 2;

  typedef logic [DW-1:0] byte_t;
  typedef logic [NFIELD-1:0][DW-1:0] alm_regs_t;

  // A field matches when masked by bit 7 or when its low w bits are equal.
  function automatic logic field_hit(input byte_t a, input byte_t t, input int unsigned w);
    byte_t m;
    m = byte_t'((32'd1 << w) - 32'd1);
    return a[DW-1] | (((a ^ t) & m) == '0);
  endfunction
endpackage

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  alm_regs_t     now_i,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_slot,
  input  byte_t         wr_data,
  input  logic          touch,
  output alm_regs_t     regs_o,
  output logic          flag_o
);
  alm_regs_t regs_q;
  logic      hit;
  logic      flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) regs_q <= '0;
    else if (wr_en) regs_q[wr_slot] <= wr_data;
  end

  always_comb begin
    hit = 1'b1;
    for (int f = 0; f < NFIELD; f++)
      hit &= field_hit(regs_q[f], now_i[f], (f == NFIELD-1) ? DAY_W : TIME_W);
  end

  // A match on the update wins over a clear by access on the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (upd_i && hit) flag_q <= 1'b1;
    else if (touch) flag_q <= 1'b0;
  end

  assign regs_o = regs_q;
  assign flag_o = flag_q;

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !touch) |=> flag_q);
  assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(upd_i));
endmodule

// File: rtl/tod_alarm_regif.sv
module tod_alarm_regif
  import tod_alarm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  byte_t                     req_addr,
  input  byte_t                     req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output byte_t                     rsp_data,
  input  alm_regs_t [NALM-1:0]      alm_rd,
  input  logic [NALM-1:0]           flags_i,
  output logic                      wp_o,
  output logic                      sq_en_o,
  output logic [NALM-1:0]           aie_o,
  output logic [NALM-1:0]           wr_en_o,
  output logic [IW-1:0]             wr_slot_o,
  output logic [NALM-1:0]           touch_o
);
  logic            acc, is_wr;
  logic [AW-1:0]   a7;
  logic [NALM-1:0] in_alm;
  logic [NALM-1:0][IW-1:0] slot;
  logic            wp_q, sq_q, rv_q;
  logic [NALM-1:0] aie_q;
  byte_t           rd_val, rd_q;

  assign req_ready = !rv_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign is_wr     = req_addr[DW-1];
  assign a7        = req_addr[AW-1:0];

  always_comb begin
    for (int k = 0; k < NALM; k++) begin
      logic [AW-1:0] off;
      off       = a7 - AW'(int'(A_ALM0) + k*NFIELD);
      in_alm[k] = (off < AW'(NFIELD));
      slot[k]   = off[IW-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (a7 == A_CTRL) rd_val = {1'b0, wp_q, 3'b000, sq_q, aie_q};
    else if (a7 == A_STAT) rd_val = {{(DW-NALM){1'b0}}, flags_i};
    for (int k = 0; k < NALM; k++)
      if (in_alm[k]) rd_val = alm_rd[k][slot[k]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      if (rv_q && rsp_ready) rv_q <= 1'b0;
      if (acc && !is_wr) begin
        rv_q <= 1'b1;
        rd_q <= rd_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= 1'b1;
      sq_q  <= 1'b0;
      aie_q <= '0;
    end else if (acc && is_wr && a7 == A_CTRL) begin
      wp_q <= req_wdata[CB_WP];
      if (!wp_q) begin
        sq_q  <= req_wdata[CB_SQ];
        aie_q <= req_wdata[NALM-1:0];
      end
    end
  end

  generate
    for (genvar k = 0; k < NALM; k++) begin : g_strobe
      assign wr_en_o[k] = acc && is_wr && in_alm[k] && !wp_q;
      assign touch_o[k] = acc && in_alm[k];
    end
  endgenerate

  assign wr_slot_o = a7[IW-1:0] - A_ALM0[IW-1:0];
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign wp_o      = wp_q;
  assign sq_en_o   = sq_q;
  assign aie_o     = aie_q;

  assert_ctrl_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_wr && a7 == A_CTRL && wp_q) |=> $stable({sq_q, aie_q}));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !rsp_ready) |=> (rv_q && $stable(rd_q)));
endmodule

// File: rtl/tod_alarm_ctrl.sv
module tod_alarm_ctrl
  import tod_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_i,
  input  logic        half_i,
  input  logic [7:0]  now_sec,
  input  logic [7:0]  now_min,
  input  logic [7:0]  now_hour,
  input  logic [7:0]  now_day,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  output logic [1:0]  alm_irq,
  output logic        sq_out,
  output logic        sq_oe
);
  alm_regs_t [NALM-1:0] alm_arr;
  alm_regs_t            now_v;
  logic [NALM-1:0]      flags, aie, wr_en, touch;
  logic [IW-1:0]        wr_slot;
  logic                 wp, sq_en, sq_q;

  assign now_v = {now_day, now_hour, now_min, now_sec};

  tod_alarm_regif u_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .alm_rd(alm_arr), .flags_i(flags),
    .wp_o(wp), .sq_en_o(sq_en), .aie_o(aie),
    .wr_en_o(wr_en), .wr_slot_o(wr_slot), .touch_o(touch)
  );

  generate
    for (genvar k = 0; k < NALM; k++) begin : g_alm
      tod_alarm_unit u_unit (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .now_i(now_v),
        .wr_en(wr_en[k]), .wr_slot(wr_slot), .wr_data(req_wdata),
        .touch(touch[k]), .regs_o(alm_arr[k]), .flag_o(flags[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sq_q <= 1'b0;
    else if (half_i) sq_q <= ~sq_q;
  end

  assign alm_irq = flags & aie;
  assign sq_out  = sq_q;
  assign sq_oe   = sq_en;

  logic acc_wr_alm;
  assign acc_wr_alm = req_valid && req_ready && req_addr[7] &&
                      (req_addr[AW-1:0] >= A_ALM0) &&
                      (req_addr[AW-1:0] < AW'(int'(A_ALM0) + NALM*NFIELD));

  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_alm && wp) |=> $stable(alm_arr));
  assert_sq_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    half_i |=> (sq_q != $past(sq_q)));
endmodule

// File: tb/tod_alarm_ctrl_tb.sv
module tod_alarm_ctrl_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, upd_i = 0, half_i = 0;
  logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_day = 0;
  logic req_valid = 0, rsp_ready = 1;
  logic [7:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, sq_out, sq_oe;
  logic [7:0] rsp_data;
  logic [1:0] alm_irq;

  int vec = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_alm [2][4];
  logic m_wp, m_sq;
  logic [1:0] m_aie, m_flag;

  always #(CLK_NS/2) clk = ~clk;

  tod_alarm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .half_i(half_i),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_day(now_day),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .alm_irq(alm_irq), .sq_out(sq_out), .sq_oe(sq_oe)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic bit fld_ok(logic [7:0] a, logic [7:0] t, bit is_day);
    if (a[7]) return 1'b1;
    if (is_day) return a[2:0] == t[2:0];
    return a[6:0] == t[6:0];
  endfunction

  function automatic logic [7:0] exp_rd(logic [6:0] a);
    if (a >= 7 && a <= 14) return m_alm[(a-7)/4][(a-7)%4];
    if (a == 15) return {1'b0, m_wp, 3'b000, m_sq, m_aie};
    if (a == 16) return {6'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic model_access(logic [6:0] a, bit wr, logic [7:0] d);
    if (a >= 7 && a <= 14) begin
      m_flag[(a-7)/4] = 1'b0;
      if (wr && !m_wp) m_alm[(a-7)/4][(a-7)%4] = d;
    end
    if (wr && a == 15) begin
      if (!m_wp) begin m_sq = d[2]; m_aie = d[1:0]; end
      m_wp = d[6];
    end
  endtask

  task automatic model_tick();
    for (int k = 0; k < 2; k++)
      if (fld_ok(m_alm[k][0], now_sec, 0) && fld_ok(m_alm[k][1], now_min, 0) &&
          fld_ok(m_alm[k][2], now_hour, 0) && fld_ok(m_alm[k][3], now_day, 1))
        m_flag[k] = 1'b1;
  endtask

  task automatic check_pins(string tag);
    check8({tag, " irq"}, {6'b0, alm_irq}, {6'b0, m_flag & m_aie});
    check8({tag, " sq_oe"}, {7'b0, sq_oe}, {7'b0, m_sq});
  endtask

  task automatic do_wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = {1'b1, a}; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    model_access(a, 1, d);
  endtask

  task automatic do_rd(logic [6:0] a, string tag);
    logic [7:0] e;
    @(negedge clk);
    req_valid = 1; req_addr = {1'b0, a};
    e = exp_rd(a);
    @(negedge clk);
    req_valid = 0;
    check8({tag, " rsp_valid"}, {7'b0, rsp_valid}, 8'h01);
    check8({tag, " rsp_data"}, rsp_data, e);
    model_access(a, 0, 8'h00);
  endtask

  task automatic do_tick(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dy, string tag);
    @(negedge clk);
    now_sec = s; now_min = mi; now_hour = h; now_day = dy; upd_i = 1;
    @(negedge clk);
    upd_i = 0;
    model_tick();
    check_pins(tag);
  endtask

  task automatic set_alarm(int k, logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dy);
    do_wr(7'(7 + 4*k), s); do_wr(7'(8 + 4*k), mi);
    do_wr(7'(9 + 4*k), h); do_wr(7'(10 + 4*k), dy);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] e, s0;
    void'($urandom(32'h1d2c3b4a));
    for (int k = 0; k < 2; k++) for (int f = 0; f < 4; f++) m_alm[k][f] = 8'h00;
    m_wp = 1; m_sq = 0; m_aie = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7: reset state
    check8("R7 irq", {6'b0, alm_irq}, 8'h00);
    check8("R7 sq_oe", {7'b0, sq_oe}, 8'h00);
    check8("R7 sq_out", {7'b0, sq_out}, 8'h00);
    do_rd(7'h0F, "R7 ctrl");
    do_rd(7'h10, "R7 status");
    do_rd(7'h0A, "R7 alarm0 day");

    // R6: protect blocks alarm writes and low control bits
    do_wr(7'h07, 8'h12);
    do_rd(7'h07, "R6 alarm blocked");
    do_wr(7'h0F, 8'h07);
    do_rd(7'h0F, "R6 ctrl low bits held");
    do_wr(7'h0F, 8'h07);
    do_rd(7'h0F, "R5 ctrl write");
    do_wr(7'h0F, 8'hFF);
    do_rd(7'h0F, "R5 ctrl unused bits zero");
    do_wr(7'h0F, 8'h00);
    do_rd(7'h0F, "R6 only protect cleared");
    do_wr(7'h0F, 8'h03);
    check_pins("R5 enables");

    // R1: every-second alarm with all masks
    set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
    do_tick(8'h33, 8'h12, 8'h07, 8'h05, "R1 all masked");
    do_rd(7'h07, "R10 alarm0 sec");
    check_pins("R3 cleared by read");
    // R1: seconds only
    set_alarm(0, 8'h25, 8'h80, 8'h80, 8'h80);
    do_tick(8'h26, 8'h00, 8'h00, 8'h00, "R1 seconds differ");
    do_tick(8'h25, 8'h44, 8'h11, 8'h02, "R1 seconds match");
    // R3: sticky over non-matching update
    do_tick(8'h27, 8'h44, 8'h11, 8'h02, "R3 sticky");
    // R4: flag visible in status while irq off
    do_wr(7'h0F, 8'h02);
    check_pins("R4 enable off");
    do_rd(7'h10, "R4 status keeps flag");
    do_wr(7'h0F, 8'h03);
    // R1: day compares low three bits only
    set_alarm(1, 8'h10, 8'h20, 8'h08, 8'h03);
    do_tick(8'h10, 8'h20, 8'h08, 8'h0B, "R1 day low bits");
    do_tick(8'h10, 8'h20, 8'h48, 8'h03, "R1 hour bit6");
    do_wr(7'h0E, 8'h03);
    check_pins("R3 cleared by write");
    // R2: no update, no flag
    @(negedge clk);
    now_sec = 8'h10; now_min = 8'h20; now_hour = 8'h08; now_day = 8'h03;
    repeat (2) @(negedge clk);
    check_pins("R2 no strobe");
    // R3: set wins over clear on same cycle
    @(negedge clk);
    req_valid = 1; req_addr = 8'h0B; upd_i = 1;
    e = exp_rd(7'h0B);
    @(negedge clk);
    req_valid = 0; upd_i = 0;
    check8("R3 same-cycle rsp", rsp_data, e);
    model_access(7'h0B, 0, 8'h00);
    model_tick();
    check_pins("R3 set wins");

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 8'h0F;
    e = exp_rd(7'h0F);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      check8("R9 held valid", {7'b0, rsp_valid}, 8'h01);
      check8("R9 ready low", {7'b0, req_ready}, 8'h00);
      check8("R9 held data", rsp_data, e);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    check8("R9 drained", {7'b0, rsp_valid}, 8'h00);
    check8("R9 ready back", {7'b0, req_ready}, 8'h01);

    // R8: square wave
    do_wr(7'h0F, 8'h07);
    check_pins("R8 oe on");
    s0 = {7'b0, sq_out};
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk); half_i = 1;
      @(negedge clk); half_i = 0;
      check8("R8 toggle", {7'b0, sq_out}, s0 ^ 8'(i % 2));
    end

    // R10: unmapped access
    do_rd(7'h20, "R10 unmapped read");
    do_wr(7'h11, 8'hAA);
    do_rd(7'h10, "R10 status read-only");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) begin
        logic [7:0] d;
        d = 8'($urandom);
        d[7] = ($urandom % 3 == 0);
        do_wr(7'(7 + $urandom % 8), d);
        check_pins("R10 random write");
      end else if (op == 1) begin
        logic [7:0] d;
        d = 8'($urandom);
        if ($urandom % 4 != 0) d[6] = 1'b0;
        do_wr(7'h0F, d);
        check_pins("R6 random ctrl");
      end else if (op == 2) begin
        do_rd(7'($urandom % 20), "R5 random read");
      end else begin
        int k;
        logic [7:0] t [4];
        k = $urandom % 2;
        for (int f = 0; f < 4; f++)
          t[f] = ($urandom % 3 != 0) ? m_alm[k][f] ^ {1'b0, 7'($urandom % 2)} : 8'($urandom);
        do_tick(t[0], t[1], t[2], t[3], "R1 random tick");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule